// File: doc/BRIEF.md
# SD Host Single-Address DMA Transfer Sequencer

This block drives the memory side of a single-address DMA data transfer in an SD host controller. Software programs a start address, a block length, an address boundary size, a block count and a transfer mode through a small register port. The block then issues one word-wide memory request per four bytes, using a valid/ready handshake. Each request carries its address and a flag that says whether memory is written (the card is being read) or read (the card is being written).

The sequencer counts bytes inside the current block and counts blocks down. Whenever the next address would land on a multiple of the programmed boundary size while data is still left, it stops and raises a boundary status bit. Software continues the transfer by rewriting the system address register. When the final block ends, the sequencer raises a transfer-complete status bit and goes idle. Status bits are write-one-to-clear, and each one is gated by an enable mask.

Register indices on `reg_addr`: 0 system address, 1 block geometry, 2 block count, 3 transfer mode, 4 DMA select, 5 status, 6 status enable. Reads return the register selected by `reg_addr` in the same cycle.

Top module: `sdma_seq_top`

## Requirements
- R1: After reset every register (indices 0 to 6) reads 0 and `mem_req_valid` is low.
- R2: Writing the transfer mode register (index 3) with bit 0 set starts a transfer, provided the block is idle, DMA select (index 4, bits [4:3]) is 00 and the block length is nonzero. Requests start at the system address and step by 4 per accepted request. `mem_req_to_mem` equals mode bit 4 (1 = read from card).
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address stays unchanged.
- R4: The block length is in geometry bits [11:0], in bytes, and each block takes ceil(length/4) requests. With mode bit 5 (multi-block) and bit 1 (count enable) both set, exactly count (index 2) blocks are moved. The count register decrements per block and reads 0 at the end.
- R5: With mode bit 5 clear, exactly one block is moved and the count register keeps its value.
- R6: The boundary size is 4096 << geometry bits [14:12]. After an accepted request whose successor address is a multiple of that size, if data remains, requests stop and status bit 3 is set.
- R7: Writing the system address register while stopped at a boundary loads the written address and resumes the transfer from it.
- R8: Writing the system address register while idle only loads the address, which reads back; no request is issued.
- R9: When the last block ends, status bit 1 is set and requests stop. If the last block ends exactly on a boundary, only bit 1 is raised and there is no stop at the boundary.
- R10: Writing 1 to a status bit (index 5) clears it, and bits written with 0 keep their value.
- R11: A status bit is set only if the same bit is set in the status enable register (index 6). Stopping at a boundary and at completion happens either way.
- R12: A start is ignored if DMA select is not 00, if the block length is 0, or if multi-block with count enable is requested with a block count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Contents of the register at `reg_addr` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_req_to_mem | output | 1 | 1 = write memory (card read), 0 = read memory |

## Verification
The end of the last block and an address boundary can fall on the same accepted request. In that cycle the completion logic and the boundary logic both want to act. The case is provoked with one block of 16 bytes that starts 16 bytes below a 4 KiB boundary. It is judged by seeing transfer-complete set with no boundary stop, no boundary status bit, and a final address equal to the boundary. A second case puts a boundary at the end of a block that is not the last, which must stop the transfer and then resume at the rewritten address.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int REG_AW        = 3;
    localparam int REG_DW        = 32;
    localparam int STAT_W        = 16;
    localparam int BND_W         = 3;
    localparam int BND_BASE_LOG2 = 12;
    localparam int WORD_BYTES    = 4;
    localparam int ST_DONE_BIT   = 1;
    localparam int ST_BND_BIT    = 3;

    typedef enum logic [REG_AW-1:0] {
        RG_SYSADDR = 3'd0,
        RG_GEOM    = 3'd1,
        RG_BCOUNT  = 3'd2,
        RG_MODE    = 3'd3,
        RG_DMASEL  = 3'd4,
        RG_STAT    = 3'd5,
        RG_STATEN  = 3'd6
    } reg_idx_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_HALT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic multi;
        logic dir_rd;
        logic auto_stop;
        logic cnt_en;
        logic dma_en;
    } xfer_mode_t;

    typedef struct packed {
        logic [BND_W-1:0] bnd_code;
        logic [11:0]      blk_len;
    } geom_t;

    function automatic xfer_mode_t unpack_mode(input logic [5:0] raw);
        xfer_mode_t m;
        m.dma_en    = raw[0];
        m.cnt_en    = raw[1];
        m.auto_stop = raw[2];
        m.dir_rd    = raw[4];
        m.multi     = raw[5];
        return m;
    endfunction

    function automatic logic [5:0] pack_mode(input xfer_mode_t m);
        return {m.multi, m.dir_rd, 1'b0, m.auto_stop, m.cnt_en, m.dma_en};
    endfunction

    function automatic logic [31:0] bnd_mask(input logic [BND_W-1:0] code);
        logic [31:0] one;
        one = 32'd1;
        return (one << (BND_BASE_LOG2 + int'(code))) - 32'd1;
    endfunction

endpackage

// File: rtl/sdma_cfg_regs.sv
module sdma_cfg_regs
    import sdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idle_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_idx_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic              set_done_i,
    input  logic              set_bnd_i,
    output geom_t             geom_o,
    output xfer_mode_t        mode_o,
    output logic [1:0]        dma_sel_o,
    output logic [STAT_W-1:0] stat_en_o,
    output logic [STAT_W-1:0] stat_o
);

    logic wr_geom, wr_mode, wr_sel, wr_en_mask, wr_stat;
    logic [STAT_W-1:0] evt;

    assign wr_geom    = wr_en_i && idle_i && (wr_idx_i == RG_GEOM);
    assign wr_mode    = wr_en_i && idle_i && (wr_idx_i == RG_MODE);
    assign wr_sel     = wr_en_i && idle_i && (wr_idx_i == RG_DMASEL);
    assign wr_en_mask = wr_en_i && (wr_idx_i == RG_STATEN);
    assign wr_stat    = wr_en_i && (wr_idx_i == RG_STAT);

    always_comb begin
        evt = '0;
        evt[ST_DONE_BIT] = set_done_i;
        evt[ST_BND_BIT]  = set_bnd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_o    <= '0;
            mode_o    <= '0;
            dma_sel_o <= '0;
            stat_en_o <= '0;
        end else begin
            if (wr_geom)    geom_o    <= wr_data_i[$bits(geom_t)-1:0];
            if (wr_mode)    mode_o    <= unpack_mode(wr_data_i[5:0]);
            if (wr_sel)     dma_sel_o <= wr_data_i[4:3];
            if (wr_en_mask) stat_en_o <= wr_data_i;
        end
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_o[b] <= 1'b0;
            end else if (evt[b] && stat_en_o[b]) begin
                stat_o[b] <= 1'b1;
            end else if (wr_stat && wr_data_i[b]) begin
                stat_o[b] <= 1'b0;
            end
        end
    end

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wr_data_i[ST_DONE_BIT] && !set_done_i) |=> !stat_o[ST_DONE_BIT]);

    // R11
    stat_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_o[ST_BND_BIT]) |-> $past(stat_en_o[ST_BND_BIT]));

endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic [BND_W-1:0]  bnd_code_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bnd_next_o
);

    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] mask;

    assign addr_nxt   = addr_o + ADDR_W'(WORD_BYTES);
    assign mask       = ADDR_W'(bnd_mask(bnd_code_i));
    assign bnd_next_o = ((addr_nxt & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= load_val_i;
        end else if (step_i) begin
            addr_o <= addr_nxt;
        end
    end

endmodule

// File: rtl/sdma_blk_tracker.sv
module sdma_blk_tracker
    import sdma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BSZ_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [BSZ_W-1:0] blk_len_i,
    input  logic             dec_en_i,
    input  logic             single_i,
    input  logic             cnt_load_i,
    input  logic [CNT_W-1:0] cnt_load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             blk_end_o,
    output logic             last_blk_o
);

    localparam int OFF_W = BSZ_W + 1;

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_nxt;

    assign off_nxt    = off_q + OFF_W'(WORD_BYTES);
    assign blk_end_o  = (off_nxt >= {1'b0, blk_len_i});
    assign last_blk_o = single_i || (dec_en_i && (cnt_o == CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            off_q <= '0;
        end else if (step_i) begin
            off_q <= blk_end_o ? '0 : off_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (cnt_load_i) begin
            cnt_o <= cnt_load_val_i;
        end else if (step_i && blk_end_o && dec_en_i) begin
            cnt_o <= cnt_o - CNT_W'(1);
        end
    end

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(step_i && blk_end_o && dec_en_i && (cnt_o == '0)));

    // R5
    single_keep_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (single_i && !dec_en_i && step_i && !cnt_load_i) |=> $stable(cnt_o));

endmodule

// File: rtl/sdma_seq_top.sv
module sdma_seq_top
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int BSZ_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wr_data,
    output logic [REG_DW-1:0] reg_rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_to_mem
);

    eng_state_e        state_q, state_d;
    geom_t             geom;
    xfer_mode_t        mode;
    xfer_mode_t        new_mode;
    logic [1:0]        dma_sel;
    logic [STAT_W-1:0] stat_en, stat;
    logic [CNT_W-1:0]  blk_cnt;
    logic [ADDR_W-1:0] cur_addr;
    logic              idle, wr_sys, wr_cnt, wr_mode;
    logic              start_ok, accept, step_done, step_bnd;
    logic              bnd_next, blk_end, last_blk, dec_en, single;

    assign idle     = (state_q == ENG_IDLE);
    assign wr_sys   = reg_wr_en && (reg_addr == RG_SYSADDR);
    assign wr_cnt   = reg_wr_en && idle && (reg_addr == RG_BCOUNT);
    assign wr_mode  = reg_wr_en && (reg_addr == RG_MODE);
    assign new_mode = unpack_mode(reg_wr_data[5:0]);

    assign start_ok = wr_mode && idle && new_mode.dma_en && (dma_sel == 2'b00)
                      && (geom.blk_len != '0)
                      && !(new_mode.multi && new_mode.cnt_en && (blk_cnt == '0));

    assign dec_en    = mode.multi && mode.cnt_en;
    assign single    = !mode.multi;
    assign accept    = (state_q == ENG_RUN) && mem_req_ready;
    assign step_done = accept && blk_end && last_blk;
    assign step_bnd  = accept && bnd_next && !(blk_end && last_blk);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (start_ok) state_d = ENG_RUN;
            ENG_RUN: begin
                if (step_done)     state_d = ENG_IDLE;
                else if (step_bnd) state_d = ENG_HALT;
            end
            ENG_HALT: if (wr_sys) state_d = ENG_RUN;
            default:  state_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ENG_IDLE;
        else     state_q <= state_d;
    end

    sdma_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .idle_i     (idle),
        .wr_en_i    (reg_wr_en),
        .wr_idx_i   (reg_addr),
        .wr_data_i  (reg_wr_data[STAT_W-1:0]),
        .set_done_i (step_done),
        .set_bnd_i  (step_bnd),
        .geom_o     (geom),
        .mode_o     (mode),
        .dma_sel_o  (dma_sel),
        .stat_en_o  (stat_en),
        .stat_o     (stat)
    );

    sdma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_sys && (state_q != ENG_RUN)),
        .load_val_i (reg_wr_data[ADDR_W-1:0]),
        .step_i     (accept),
        .bnd_code_i (geom.bnd_code),
        .addr_o     (cur_addr),
        .bnd_next_o (bnd_next)
    );

    sdma_blk_tracker #(.CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_blk (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_ok),
        .step_i         (accept),
        .blk_len_i      (geom.blk_len),
        .dec_en_i       (dec_en),
        .single_i       (single),
        .cnt_load_i     (wr_cnt),
        .cnt_load_val_i (reg_wr_data[CNT_W-1:0]),
        .cnt_o          (blk_cnt),
        .blk_end_o      (blk_end),
        .last_blk_o     (last_blk)
    );

    assign mem_req_valid  = (state_q == ENG_RUN);
    assign mem_req_addr   = cur_addr;
    assign mem_req_to_mem = mode.dir_rd;

    always_comb begin
        reg_rd_data = '0;
        case (reg_addr)
            RG_SYSADDR: reg_rd_data = REG_DW'(cur_addr);
            RG_GEOM:    reg_rd_data = REG_DW'(geom);
            RG_BCOUNT:  reg_rd_data = REG_DW'(blk_cnt);
            RG_MODE:    reg_rd_data = REG_DW'(pack_mode(mode));
            RG_DMASEL:  reg_rd_data = REG_DW'({dma_sel, 3'b000});
            RG_STAT:    reg_rd_data = REG_DW'(stat);
            RG_STATEN:  reg_rd_data = REG_DW'(stat_en);
            default:    reg_rd_data = '0;
        endcase
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6
    bnd_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && bnd_next && !(blk_end && last_blk)) |=> !mem_req_valid);

    // R9
    done_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && blk_end && last_blk) |=> (!mem_req_valid && !$rose(stat[ST_BND_BIT])));

    // R12
    sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid) |-> (dma_sel == 2'b00));

endmodule

// File: tb/sdma_seq_top_tb_top.sv
module sdma_seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_to_mem;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sdma_seq_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .reg_wr_en      (reg_wr_en),
        .reg_addr       (reg_addr),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_data    (reg_rd_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_req_to_mem (mem_req_to_mem)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [11:0] len;
        logic [2:0]  code;
        logic [15:0] cnt;
        logic [7:0]  mode;
        logic [15:0] exp_req;
        logic [7:0]  exp_halts;
        logic [31:0] exp_final;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 12'd16, 3'd0, 16'd3, 8'h23, 16'd12, 8'd0, 32'h0000_1030, 16'd0},
        '{32'h0000_2FF0, 12'd8,  3'd0, 16'd4, 8'h33, 16'd8,  8'd1, 32'h0000_3010, 16'd0},
        '{32'h0000_0040, 12'd32, 3'd0, 16'd5, 8'h01, 16'd8,  8'd0, 32'h0000_0060, 16'd5},
        '{32'h0000_7FF0, 12'd16, 3'd0, 16'd1, 8'h23, 16'd4,  8'd0, 32'h0000_8000, 16'd0},
        '{32'h0000_1FFC, 12'd8,  3'd1, 16'd1, 8'h03, 16'd2,  8'd1, 32'h0000_2004, 16'd1},
        '{32'h0000_0500, 12'd6,  3'd0, 16'd2, 8'h23, 16'd4,  8'd0, 32'h0000_0510, 16'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_addr    = idx;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        @(negedge clk);
        reg_addr = idx;
        #1 v = reg_rd_data;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int nreq = 0;
        int nh = 0;
        int guard = 0;
        bit done = 0;
        bit addr_bad = 0;
        bit dir_bad = 0;
        logic [31:0] ea;
        logic [31:0] fin_stat = '0;
        logic [31:0] r;
        ea = v.addr;
        mem_req_ready = 1'b0;
        wr(3'd1, {17'd0, v.code, v.len});
        wr(3'd0, v.addr);
        wr(3'd2, {16'd0, v.cnt});
        wr(3'd3, {24'd0, v.mode});
        while (!done && guard < 20000) begin
            @(negedge clk);
            mem_req_ready = 1'b1;
            reg_addr = 3'd5;
            #1;
            guard++;
            if (mem_req_valid) begin
                if (mem_req_addr !== ea) addr_bad = 1;
                if (mem_req_to_mem !== v.mode[4]) dir_bad = 1;
                ea = ea + 32'd4;
                nreq++;
            end else if (reg_rd_data[1]) begin
                done = 1;
                fin_stat = reg_rd_data;
            end else if (reg_rd_data[3]) begin
                nh++;
                mem_req_ready = 1'b0;
                wr(3'd5, 32'h8);
                wr(3'd0, ea);
            end
        end
        $display("vector %0d: requests=%0d stops=%0d", idx, nreq, nh);
        chk(!addr_bad, "R2 request address sequence", 32'(addr_bad), 32'd0);
        chk(!dir_bad, "R2 direction flag", 32'(dir_bad), 32'd0);
        chk(done, "R9 completion status", 32'(done), 32'd1);
        chk(fin_stat[3] == 1'b0, "R9 no boundary bit at completion", fin_stat, 32'h2);
        chk(nreq == int'(v.exp_req), "R4 request count", 32'(nreq), 32'(v.exp_req));
        chk(nh == int'(v.exp_halts), "R6 boundary stops", 32'(nh), 32'(v.exp_halts));
        rd(3'd0, r);
        chk(r == v.exp_final, "R7 final address", r, v.exp_final);
        rd(3'd2, r);
        chk(r[15:0] == v.exp_cnt, "R5 block count after transfer", r, 32'(v.exp_cnt));
        wr(3'd5, 32'hA);
        rd(3'd5, r);
        chk(r == 32'd0, "R10 status cleared", r, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), r);
            chk(r == 32'd0, "R1 register reset value", r, 32'd0);
        end
        chk(mem_req_valid == 1'b0, "R1 no request after reset", 32'(mem_req_valid), 32'd0);

        // R8: idle address write only loads
        wr(3'd0, 32'h0000_ABC0);
        idle_wait(3);
        chk(mem_req_valid == 1'b0, "R8 no request on idle address write", 32'(mem_req_valid), 32'd0);
        rd(3'd0, r);
        chk(r == 32'h0000_ABC0, "R8 address readback", r, 32'h0000_ABC0);

        wr(3'd6, 32'hA);
        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

        // R3: backpressure holds the request
        mem_req_ready = 1'b0;
        wr(3'd1, {17'd0, 3'd0, 12'd8});
        wr(3'd0, 32'h0000_0100);
        wr(3'd3, 32'h01);
        #1;
        chk(mem_req_valid && mem_req_addr == 32'h100, "R3 first request", mem_req_addr, 32'h100);
        idle_wait(3);
        chk(mem_req_valid && mem_req_addr == 32'h100, "R3 held under backpressure", mem_req_addr, 32'h100);
        mem_req_ready = 1'b1;
        @(negedge clk); #1;
        chk(mem_req_valid && mem_req_addr == 32'h104, "R2 second word address", mem_req_addr, 32'h104);
        @(negedge clk); #1;
        chk(mem_req_valid == 1'b0, "R9 stop after single block", 32'(mem_req_valid), 32'd0);
        rd(3'd5, r);
        chk(r == 32'h2, "R9 completion bit", r, 32'h2);
        wr(3'd5, 32'h2);

        // R6 / R7 / R10: boundary mid-block, resume, selective clear
        wr(3'd0, 32'h0000_0FFC);
        wr(3'd3, 32'h01);
        idle_wait(4);
        chk(mem_req_valid == 1'b0, "R6 stopped at boundary", 32'(mem_req_valid), 32'd0);
        rd(3'd5, r);
        chk(r == 32'h8, "R6 boundary status bit", r, 32'h8);
        wr(3'd0, 32'h0000_1000);
        idle_wait(4);
        rd(3'd5, r);
        chk(r == 32'hA, "R7 resumed to completion", r, 32'hA);
        wr(3'd5, 32'h2);
        rd(3'd5, r);
        chk(r == 32'h8, "R10 clear only written bit", r, 32'h8);
        wr(3'd5, 32'h8);
        rd(3'd5, r);
        chk(r == 32'h0, "R10 clear remaining bit", r, 32'h0);

        // R11: status enable masked off
        wr(3'd6, 32'h0);
        wr(3'd0, 32'h0000_0FFC);
        wr(3'd3, 32'h01);
        idle_wait(4);
        chk(mem_req_valid == 1'b0, "R11 still stops at boundary", 32'(mem_req_valid), 32'd0);
        rd(3'd5, r);
        chk(r == 32'h0, "R11 masked boundary bit", r, 32'h0);
        rd(3'd0, r);
        chk(r == 32'h1000, "R11 address at stop", r, 32'h1000);
        wr(3'd0, 32'h0000_1000);
        idle_wait(4);
        chk(mem_req_valid == 1'b0, "R11 completes", 32'(mem_req_valid), 32'd0);
        rd(3'd5, r);
        chk(r == 32'h0, "R11 masked completion bit", r, 32'h0);
        rd(3'd0, r);
        chk(r == 32'h1004, "R11 final address", r, 32'h1004);
        wr(3'd6, 32'hA);

        // R12: rejected starts
        wr(3'd4, 32'h10);
        wr(3'd3, 32'h01);
        idle_wait(3);
        chk(mem_req_valid == 1'b0, "R12 non-zero DMA select", 32'(mem_req_valid), 32'd0);
        wr(3'd4, 32'h0);
        wr(3'd2, 32'd0);
        wr(3'd3, 32'h23);
        idle_wait(3);
        chk(mem_req_valid == 1'b0, "R12 zero count multi-block", 32'(mem_req_valid), 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'h01);
        idle_wait(3);
        chk(mem_req_valid == 1'b0, "R12 zero block length", 32'(mem_req_valid), 32'd0);
        rd(3'd5, r);
        chk(r == 32'h0, "R12 no status from rejected starts", r, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule